// File: doc/BRIEF.md
# Write-once watchdog timer

This block is a watchdog timer configured through an 8-bit mode register and serviced through an 8-bit clear register, both written over a simple single-cycle write strobe with a one-bit register select. The mode register holds a two-bit operation field and a five-bit period field. The operation field either stops the timer, makes an overflow raise a non-maskable interrupt pulse, or makes an overflow raise a reset request. The period field sets the overflow interval to a power of two of the input clock.

Software may write the mode register once after a system reset. Any later write leaves the configuration as it is and is treated as a fault: the timer overflows at once. Software keeps the timer from overflowing by writing the key 0xAC to the clear register. Any other value written there is also a fault and forces an overflow. While the timer is stopped, neither fault produces an overflow, so writing 0x00 as the one allowed mode write stops the timer securely. The reset request is meant to drive the chip reset. The block's own configuration returns to its reset state only through the system reset input.

Top module: `wonce_wdt`

## Requirements
- R1: While `rst_n` is low at a clock edge, `cfg_rd` becomes 0x67 and `nmi_pulse` and `rst_req` become 0. The reset configuration is reset mode with k = 7, and the timer counts from reset.
- R2: `cfg_rd` always shows the stored mode byte. Bits [6:5] are the operation field and bits [4:0] are the period field. Bit 7 is stored and read back with no other effect.
- R3: The first write to the mode register after reset (`wr_sel` = 0) stores `wr_data` and restarts the count from zero. Every later mode write leaves `cfg_rd` unchanged.
- R4: When the operation field is not 00, a mode write after the first one forces an overflow pulse in the cycle after its write edge and restarts the count.
- R5: A clear-register write (`wr_sel` = 1) of 0xAC restarts the count from zero without an overflow. The next natural overflow comes one full period after that write edge.
- R6: When the operation field is not 00, a clear-register write of any value other than 0xAC forces an overflow pulse in the cycle after its write edge and restarts the count.
- R7: Operation field 00 stops the timer. It produces no natural overflow, and neither a later mode write nor a wrong clear key produces an overflow.
- R8: The overflow period is 2^(BASE_EXP + k) clock cycles, where k is period-field bits [2:0] and BASE_EXP defaults to 10. Period-field bits [4:3] have no effect on timing.
- R9: Operation field 01 routes every overflow to `nmi_pulse`. Operation field 1x routes every overflow to `rst_req`. Each overflow gives a one-cycle pulse on that output only, and the count restarts from zero.
- R10: A clear-register write made before any mode write is accepted. It restarts the count, and the reset configuration stays in force and remains writable once.
- R11: A `rst_req` pulse does not reset the mode register or the write-once lock. Only `rst_n` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and register clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_sel | input | 1 | Register select: 0 = mode register, 1 = clear register |
| wr_data | input | 8 | Write data |
| cfg_rd | output | 8 | Current mode register contents |
| nmi_pulse | output | 1 | One-cycle non-maskable interrupt request on overflow |
| rst_req | output | 1 | One-cycle reset request on overflow |

## Verification
A forced overflow is registered once. It shows on the output in the cycle after the write edge that caused it. A natural overflow shows exactly P cycles after the edge that last restarted the count, where P is 2^(BASE_EXP + k). Each bench task drives its inputs on the falling edge and samples on the next falling edge after the write edge. For a natural overflow the task counts P rising edges from the restarting write, checks that no pulse appeared earlier, and checks the pulse in that exact cycle on the selected output only. The bench uses a small BASE_EXP so that the largest period, k = 7 from reset, still fits in a short run.

// File: rtl/wonce_wdt_pkg.sv
// Package: shared constants, operation encoding and field decoders for the
// write-once watchdog. Assumes the fixed 8-bit mode byte layout:
// [7] spare, [6:5] operation, [4:0] period select.
package wonce_wdt_pkg;

    localparam int          REG_W    = 8;
    localparam int          OP_LSB   = 5;
    localparam int          PER_W    = 3;
    localparam logic [7:0]  CFG_INIT = 8'h67;
    localparam logic [7:0]  CLR_KEY  = 8'hAC;

    typedef enum logic [1:0] {
        OP_STOP = 2'd0,
        OP_NMI  = 2'd1,
        OP_RST  = 2'd2
    } op_e;

    // Decode the operation field; any value with the upper bit set is reset mode.
    function automatic op_e op_of(input logic [REG_W-1:0] cfg);
        case (cfg[OP_LSB+1:OP_LSB])
            2'b00:   return OP_STOP;
            2'b01:   return OP_NMI;
            default: return OP_RST;
        endcase
    endfunction

    // Extract the period exponent offset k (low bits of the period field).
    function automatic logic [PER_W-1:0] per_of(input logic [REG_W-1:0] cfg);
        return cfg[PER_W-1:0];
    endfunction

endpackage

// File: rtl/wonce_wdt_cfg.sv
// Module: mode register with write-once lock and write decoding.
// Holds the mode byte and the lock flag, both cleared only by rst_n.
// Produces a restart request (first mode write, correct clear key) and a
// forced-overflow request (repeat mode write, wrong key) gated off in stop mode.
// Assumes at most one register write per cycle.
module wonce_wdt_cfg
    import wonce_wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] cfg_q,
    output logic             locked_q,
    output op_e              op,
    output logic [PER_W-1:0] per,
    output logic             restart,
    output logic             force_ovf
);

    logic mode_wr;
    logic clr_wr;
    logic key_ok;
    logic stopped;

    // Decode the write strobe into the two register targets.
    always_comb begin
        mode_wr = wr_en && !wr_sel;
        clr_wr  = wr_en &&  wr_sel;
        key_ok  = (wr_data == CLR_KEY);
    end

    // Store the mode byte on the first mode write only and set the lock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q    <= CFG_INIT;
            locked_q <= 1'b0;
        end else if (mode_wr && !locked_q) begin
            cfg_q    <= wr_data;
            locked_q <= 1'b1;
        end
    end

    // Derive the live configuration and the restart / fault requests.
    always_comb begin
        op        = op_of(cfg_q);
        per       = per_of(cfg_q);
        stopped   = (op == OP_STOP);
        restart   = (mode_wr && !locked_q) || (clr_wr && key_ok);
        force_ovf = !stopped && ((mode_wr && locked_q) || (clr_wr && !key_ok));
    end

    // R3: once locked, a mode write leaves the stored byte untouched.
    assert_cfg_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_q && wr_en && !wr_sel) |=> (cfg_q == $past(cfg_q)));

    // R11: the lock never drops without the system reset.
    assert_lock_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        locked_q |=> locked_q);

endmodule

// File: rtl/wonce_wdt_cnt.sv
// Module: period counter. Counts input clocks while running and reports a
// natural overflow (tick) when the count reaches 2^(BASE_EXP+k)-1. A clear
// request or the stopped state holds the count at zero. Assumes k changes
// only in a cycle where clear is asserted.
module wonce_wdt_cnt #(
    parameter int BASE_EXP = 10,
    parameter int PER_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clear,
    input  logic [PER_W-1:0] per,
    output logic             tick
);

    localparam int CNT_W  = BASE_EXP + (1 << PER_W) - 1;
    localparam int SPAN_W = CNT_W + 1;

    logic [CNT_W-1:0]  cnt;
    logic [SPAN_W-1:0] span;
    logic [CNT_W-1:0]  last;

    // Compute the terminal count for the selected period.
    always_comb begin
        span = SPAN_W'(1) << (BASE_EXP + int'(per));
        last = CNT_W'(span - SPAN_W'(1));
        tick = run && !clear && (cnt == last);
    end

    // Advance, wrap or hold the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || clear || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // R8: the count never passes the terminal value of the live period.
    assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= last);

    // R7: a stopped timer sits at zero.
    assert_cnt_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0));

endmodule

// File: rtl/wonce_wdt_evt.sv
// Module: overflow output stage. Registers one overflow event onto the
// output chosen by the live operation, as a one-cycle pulse. Assumes the
// caller raises ovf for one cycle per event.
module wonce_wdt_evt
    import wonce_wdt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ovf,
    input  op_e  op,
    output logic nmi_o,
    output logic rst_o
);

    // Steer the event to the interrupt or reset-request output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_o <= 1'b0;
            rst_o <= 1'b0;
        end else begin
            nmi_o <= ovf && (op == OP_NMI);
            rst_o <= ovf && (op == OP_RST);
        end
    end

    // R9: never both outputs in one cycle.
    assert_one_output_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({nmi_o, rst_o}));

endmodule

// File: rtl/wonce_wdt.sv
// Module: write-once watchdog timer top. Connects the mode register and
// write decoder, the period counter and the overflow output stage.
// Assumes a synchronous active-low system reset and one write per cycle.
module wonce_wdt
    import wonce_wdt_pkg::*;
#(
    parameter int BASE_EXP = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] cfg_rd,
    output logic             nmi_pulse,
    output logic             rst_req
);

    logic [REG_W-1:0] cfg_q;
    logic             locked_q;
    op_e              op;
    logic [PER_W-1:0] per;
    logic             restart;
    logic             force_ovf;
    logic             tick;
    logic             run;
    logic             ovf;

    wonce_wdt_cfg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .cfg_q     (cfg_q),
        .locked_q  (locked_q),
        .op        (op),
        .per       (per),
        .restart   (restart),
        .force_ovf (force_ovf)
    );

    // Combine the run state and the overflow sources.
    always_comb begin
        run    = (op != OP_STOP);
        ovf    = force_ovf || tick;
        cfg_rd = cfg_q;
    end

    wonce_wdt_cnt #(
        .BASE_EXP (BASE_EXP),
        .PER_W    (PER_W)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .clear (restart || force_ovf),
        .per   (per),
        .tick  (tick)
    );

    wonce_wdt_evt u_evt (
        .clk   (clk),
        .rst_n (rst_n),
        .ovf   (ovf),
        .op    (op),
        .nmi_o (nmi_pulse),
        .rst_o (rst_req)
    );

    // R7: a stopped timer produces no output in the next cycle.
    assert_stop_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_STOP) |=> !(nmi_pulse || rst_req));

    // R4: a repeat mode write in a running mode fires an overflow.
    assert_rewrite_fires_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel && locked_q && op != OP_STOP) |=> (nmi_pulse || rst_req));

    // R6: a wrong clear key in a running mode fires an overflow.
    assert_bad_key_fires_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel && wr_data != CLR_KEY && op != OP_STOP) |=> (nmi_pulse || rst_req));

    // R9: an overflow in interrupt mode lands on the interrupt output only.
    assert_nmi_route_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && op == OP_NMI) |=> (nmi_pulse && !rst_req));

endmodule

// File: tb/wonce_wdt_tb.sv
`timescale 1ns/1ps
// Directed bench for the write-once watchdog; each task checks its own results.
module wonce_wdt_tb;

    localparam int BEXP = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] cfg_rd;
    logic       nmi_pulse;
    logic       rst_req;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    wonce_wdt #(.BASE_EXP(BEXP)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .cfg_rd    (cfg_rd),
        .nmi_pulse (nmi_pulse),
        .rst_req   (rst_req)
    );

    // Watchdog on the run itself.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: got %0d cycles exp below 150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int got, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: got 0x%0h exp 0x%0h", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Drive one write; return at the falling edge after its write edge.
    task automatic do_write(input bit sel, input logic [7:0] data);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_sel  = sel;
        wr_data = data;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // Expect a natural overflow exactly p cycles after the last restart edge.
    task automatic wait_expect(input int p, input bit on_rst, input string tag);
        int early = 0;
        for (int i = 1; i <= p; i++) begin
            @(negedge clk);
            if (i < p && (nmi_pulse || rst_req)) early++;
            if (i == p) begin
                chk(on_rst ? rst_req : nmi_pulse, {tag, " pulse on time"},
                    on_rst ? rst_req : nmi_pulse, 1);
                chk(!(on_rst ? nmi_pulse : rst_req), {tag, " other output idle"},
                    on_rst ? nmi_pulse : rst_req, 0);
            end
        end
        chk(early == 0, {tag, " no early pulse"}, early, 0);
    endtask

    // Expect no pulse at all for n cycles.
    task automatic quiet(input int n, input string tag);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (nmi_pulse || rst_req) seen++;
        end
        chk(seen == 0, tag, seen, 0);
    endtask

    task automatic t_reset_state();
        do_reset();
        @(negedge clk);
        chk(cfg_rd == 8'h67, "R1 reset mode byte", cfg_rd, 8'h67);
        chk(!nmi_pulse && !rst_req, "R1 outputs low", {nmi_pulse, rst_req}, 0);
    endtask

    task automatic t_clear_before_mode();
        do_write(1'b1, 8'hAC);
        chk(!nmi_pulse && !rst_req, "R5 good key no pulse", {nmi_pulse, rst_req}, 0);
        wait_expect(1 << (BEXP + 7), 1'b1, "R10 reset-mode k=7 from reset config");
        @(negedge clk);
        chk(cfg_rd == 8'h67, "R11 mode byte kept after rst_req", cfg_rd, 8'h67);
    endtask

    task automatic t_first_write_nmi();
        // 0x39: bit7=0, op=01 (interrupt), period field 11001 -> k=1, bits[4:3] set.
        do_write(1'b0, 8'h39);
        chk(cfg_rd == 8'h39, "R3 R11 first write taken after rst_req", cfg_rd, 8'h39);
        wait_expect(1 << (BEXP + 1), 1'b0, "R8 k=1 ignores upper period bits");
        wait_expect(1 << (BEXP + 1), 1'b0, "R9 overflow restarts count");
    endtask

    task automatic t_rewrite_fault();
        do_write(1'b0, 8'h00);
        chk(nmi_pulse && !rst_req, "R4 repeat mode write forces nmi", {nmi_pulse, rst_req}, 2);
        chk(cfg_rd == 8'h39, "R3 repeat write ignored", cfg_rd, 8'h39);
        wait_expect(1 << (BEXP + 1), 1'b0, "R4 count restarted by fault");
    endtask

    task automatic t_bad_key();
        repeat (7) @(negedge clk);
        do_write(1'b1, 8'h55);
        chk(nmi_pulse && !rst_req, "R6 wrong key forces nmi", {nmi_pulse, rst_req}, 2);
        wait_expect(1 << (BEXP + 1), 1'b0, "R6 count restarted by wrong key");
    endtask

    task automatic t_good_key_mid();
        repeat (20) @(negedge clk);
        do_write(1'b1, 8'hAC);
        chk(!nmi_pulse && !rst_req, "R5 key mid period no pulse", {nmi_pulse, rst_req}, 0);
        wait_expect(1 << (BEXP + 1), 1'b0, "R5 full period after key");
    endtask

    task automatic t_stop_mode();
        do_reset();
        do_write(1'b0, 8'h00);
        chk(cfg_rd == 8'h00, "R7 stop mode stored", cfg_rd, 8'h00);
        quiet(3000, "R7 stopped timer never overflows");
        do_write(1'b0, 8'h39);
        chk(!nmi_pulse && !rst_req, "R7 repeat write silent when stopped", {nmi_pulse, rst_req}, 0);
        chk(cfg_rd == 8'h00, "R3 stop mode stays locked", cfg_rd, 8'h00);
        do_write(1'b1, 8'h12);
        chk(!nmi_pulse && !rst_req, "R7 wrong key silent when stopped", {nmi_pulse, rst_req}, 0);
        quiet(40, "R7 still quiet after faults");
    endtask

    task automatic t_reset_mode();
        // 0x40: op=10 (reset mode), k=0.
        do_reset();
        do_write(1'b0, 8'h40);
        chk(cfg_rd == 8'h40, "R2 mode byte readback", cfg_rd, 8'h40);
        wait_expect(1 << BEXP, 1'b1, "R9 reset mode k=0");
        repeat (3) @(negedge clk);
        do_write(1'b1, 8'h00);
        chk(rst_req && !nmi_pulse, "R6 wrong key forces rst_req", {nmi_pulse, rst_req}, 1);
        @(negedge clk);
        chk(!rst_req, "R9 rst_req lasts one cycle", rst_req, 0);
        chk(cfg_rd == 8'h40, "R11 config survives rst_req", cfg_rd, 8'h40);
    endtask

    initial begin
        t_reset_state();
        t_clear_before_mode();
        t_first_write_nmi();
        t_rewrite_fault();
        t_bad_key();
        t_good_key_mid();
        t_stop_mode();
        t_reset_mode();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule